// File: doc/BRIEF.md
# Trigger-Driven Slave Timer

This block is a 16-bit up-counter with a slave controller. The controller chooses where the counter gets its clock and its enable. A trigger multiplexer selects one of four trigger lines that come from other timers. A mode field then decides how the selected line acts on the counter:

- as an edge clock, where each rising edge counts once;
- as a level gate on the prescaled internal tick;
- not at all, in which case the counter runs freely from its prescaler.

Typical uses are cascading two timers, so that one acts as a prescaler for the other, and letting one timer's output window the counting of another. The counter wraps at a programmable reload value. On each wrap it raises a one-cycle update pulse, whatever the clock source.

The selected trigger is registered once on the internal clock. A rising edge is detected by comparing that sample with the sample one cycle older, so trigger lines must stay low and high for at least one clock each.

Top module: `slave_timer`

## Requirements
- R1: Trigger select codes 0 to 3 route `trig_in[code]` to the controller. Codes 4 to 7 route a constant low, so no trigger activity reaches the counter.
- R2: With `slave_mode` = 3'b111 (edge clock), each rising edge of the selected trigger advances `count` by exactly one. The new value appears after the second clock edge that follows the trigger change. The prescaler plays no part in this mode.
- R3: With `slave_mode` = 3'b101 (gated), `count` advances on the prescaled tick only while the selected trigger is high. The trigger is seen one clock after it changes. Each clock during which the trigger is high contributes exactly one prescaler cycle.
- R4: In gated mode the prescaler keeps its phase while the gate is low and resumes from that phase. After gate-high spans totalling H clocks, `count` equals floor(H / (psc_div+1)).
- R5: While `cnt_en` is low, `count` holds its value in every mode, and trigger edges are not counted.
- R6: With `slave_mode` = 3'b000 or any code other than 3'b101 and 3'b111, the counter advances once every `psc_div`+1 clocks while `cnt_en` is high.
- R7: A step taken while `count` equals `reload` sets `count` to 0 and raises `update` for exactly that one cycle. Between wraps `count` steps by +1.
- R8: While `rst_n` is low, `count`, `update`, the prescaler phase and the trigger samples are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Counter enable |
| slave_mode | input | 3 | 000 free-running, 101 gated, 111 edge clock |
| trig_sel | input | 3 | Trigger select, 0 to 3 valid |
| psc_div | input | 16 | Prescaler divides by psc_div+1 |
| reload | input | 16 | Wrap value of the counter |
| trig_in | input | 4 | Trigger lines from other timers |
| count | output | 16 | Counter value |
| update | output | 1 | One-cycle pulse on wrap |

## Verification
Any fault in the trigger sampler, the prescaler phase or the step decode shows up directly in `count`, and the bench compares that value with a closed-form result at the end of each scenario. An edge detector that counts levels, or that misses edges, leaves a wrong count within two clocks of the first pulse. A prescaler that drops its phase while the gate is low only shows up after several short gate windows, which is why the gated scenario uses spans that are not multiples of the divide ratio. A wrong wrap shows as a missing or extra `update` pulse at the cycle where `count` returns to zero.

// File: rtl/slave_tmr_pkg.sv
package slave_tmr_pkg;
  localparam logic [2:0] SM_OFF    = 3'b000;
  localparam logic [2:0] SM_GATED  = 3'b101;
  localparam logic [2:0] SM_EXTCLK = 3'b111;

  // Next counter value: wrap to zero after reaching the reload value.
  function automatic logic [15:0] cnt_next(input logic [15:0] cur, input logic [15:0] top);
    return (cur == top) ? 16'd0 : cur + 16'd1;
  endfunction

  // Prescaler phase after one running clock.
  function automatic logic [15:0] psc_next(input logic [15:0] ph, input logic [15:0] div);
    return (ph == div) ? 16'd0 : ph + 16'd1;
  endfunction
endpackage

// File: rtl/stm_trig_sync.sv
module stm_trig_sync #(
  parameter int N_TRIG = 4,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  trig_sel,
  input  logic [N_TRIG-1:0] trig_in,
  output logic              trig_lvl,
  output logic              trig_rise
);
  logic picked;
  logic samp_q, samp_qq;

  // R1: only codes below N_TRIG select a line, the others give a constant low
  always_comb begin
    picked = 1'b0;
    for (int i = 0; i < N_TRIG; i++) begin
      if (trig_sel == SEL_W'(i)) picked = trig_in[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q  <= 1'b0;
      samp_qq <= 1'b0;
    end else begin
      samp_q  <= picked;
      samp_qq <= samp_q;
    end
  end

  assign trig_lvl  = samp_q;
  assign trig_rise = samp_q & ~samp_qq;
endmodule

// File: rtl/stm_prescaler.sv
module stm_prescaler
  import slave_tmr_pkg::*;
#(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PSC_W-1:0] div,
  output logic             tick
);
  logic [PSC_W-1:0] phase;

  assign tick = run && (phase == div);

  // R4: the phase is only touched while running, so it holds when the gate is low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   phase <= '0;
    else if (run) phase <= PSC_W'(psc_next(16'(phase), 16'(div)));
  end
endmodule

// File: rtl/stm_counter.sv
module stm_counter
  import slave_tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             update
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      update <= 1'b0;
    end else begin
      update <= step && (count == reload);
      if (step) count <= CNT_W'(cnt_next(16'(count), 16'(reload)));
    end
  end
endmodule

// File: rtl/slave_timer.sv
module slave_timer
  import slave_tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16,
  parameter int N_TRIG = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic [2:0]        slave_mode,
  input  logic [2:0]        trig_sel,
  input  logic [PSC_W-1:0]  psc_div,
  input  logic [CNT_W-1:0]  reload,
  input  logic [N_TRIG-1:0] trig_in,
  output logic [CNT_W-1:0]  count,
  output logic              update
);
  logic gate_lvl, gate_rise;
  logic mode_ext, mode_gate;
  logic psc_run, psc_tick, cnt_step;

  assign mode_ext  = (slave_mode == SM_EXTCLK);
  assign mode_gate = (slave_mode == SM_GATED);

  stm_trig_sync #(.N_TRIG(N_TRIG), .SEL_W(3)) u_sync (
    .clk(clk), .rst_n(rst_n), .trig_sel(trig_sel), .trig_in(trig_in),
    .trig_lvl(gate_lvl), .trig_rise(gate_rise)
  );

  assign psc_run = cnt_en && !mode_ext && (!mode_gate || gate_lvl);

  stm_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .run(psc_run), .div(psc_div), .tick(psc_tick)
  );

  assign cnt_step = mode_ext ? (cnt_en && gate_rise) : psc_tick;

  stm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(cnt_step), .reload(reload),
    .count(count), .update(update)
  );
endmodule

// File: rtl/stm_checker.sv
module stm_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_en,
  input logic [2:0]       slave_mode,
  input logic [CNT_W-1:0] reload,
  input logic [CNT_W-1:0] count,
  input logic             update,
  input logic             gate_lvl,
  input logic             gate_rise,
  input logic             cnt_step
);
  p_hold_when_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(count));

  p_update_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    update |-> (count == '0));

  p_step_plus_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_step && (count != reload)) |=> (count == $past(count) + 1'b1));

  p_ext_no_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_mode == 3'b111 && !gate_rise) |=> $stable(count));

  p_gate_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_mode == 3'b101 && !gate_lvl) |=> $stable(count));

  p_quiet_no_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_step |=> (!update && $stable(count)));
endmodule

bind slave_timer stm_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .slave_mode(slave_mode),
  .reload(reload), .count(count), .update(update), .gate_lvl(gate_lvl),
  .gate_rise(gate_rise), .cnt_step(cnt_step)
);

// File: tb/test_slave_timer.sv
module test_slave_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cnt_en;
  logic [2:0]  slave_mode, trig_sel;
  logic [15:0] psc_div, reload;
  logic [3:0]  trig_in;
  logic [15:0] count;
  logic        update;

  int checks = 0;
  int errors = 0;
  int upd_seen = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  slave_timer i_slave_timer (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .slave_mode(slave_mode),
    .trig_sel(trig_sel), .psc_div(psc_div), .reload(reload),
    .trig_in(trig_in), .count(count), .update(update)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Advance n clock edges, sample 1 ns after each edge.
  task automatic run(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
      if (update) upd_seen++;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cnt_en = 1'b0; slave_mode = 3'b000; trig_sel = 3'b000;
    psc_div = 16'd0; reload = 16'hFFFF; trig_in = 4'b0;
    run(2);
    rst_n = 1'b1;
    upd_seen = 0;
  endtask

  task automatic pulses(input int idx, input int p);
    repeat (p) begin
      trig_in[idx] = 1'b1; run(2);
      trig_in[idx] = 1'b0; run(2);
    end
  endtask

  initial begin
    do_reset();
    chk("R8 count after reset", int'(count), 0);
    chk("R8 update after reset", int'(update), 0);

    // R6: free-running sweep over divide ratios, with wraps (R7)
    for (int d = 0; d < 4; d++) begin
      do_reset();
      psc_div = 16'(d); reload = 16'd5; cnt_en = 1'b1;
      run(23);
      chk("R6 free-run count", int'(count), (23 / (d + 1)) % 6);
      chk("R7 update pulses", upd_seen, (23 / (d + 1)) / 6);
    end

    // R7: exact wrap with divide by 1
    do_reset();
    reload = 16'd3; cnt_en = 1'b1;
    run(20);
    chk("R7 count at wrap", int'(count), 0);
    chk("R7 update at wrap", int'(update), 1);
    chk("R7 wrap count", upd_seen, 5);

    // R6: an unsupported mode code behaves as free-running
    do_reset();
    slave_mode = 3'b011; psc_div = 16'd2; cnt_en = 1'b1;
    run(9);
    chk("R6 other mode code", int'(count), 3);

    // R5: hold while disabled
    do_reset();
    psc_div = 16'd2; cnt_en = 1'b1;
    run(6);
    cnt_en = 1'b0;
    run(10);
    chk("R5 hold when disabled", int'(count), 2);

    // R2 / R1: edge clock, sweep of the trigger select, noise on another line
    for (int s = 0; s < 4; s++) begin
      do_reset();
      slave_mode = 3'b111; trig_sel = 3'(s); reload = 16'd2; cnt_en = 1'b1;
      psc_div = 16'd0;
      pulses((s + 1) % 4, 3);
      chk("R1 unselected line ignored", int'(count), 0);
      pulses(s, s + 4);
      run(3);
      chk("R2 edge count", int'(count), (s + 4) % 3);
      chk("R2 edge wraps", upd_seen, (s + 4) / 3);
    end

    // R1: select code above range routes nothing
    do_reset();
    slave_mode = 3'b111; trig_sel = 3'd5; cnt_en = 1'b1;
    for (int k = 0; k < 4; k++) pulses(k, 2);
    run(3);
    chk("R1 out-of-range select", int'(count), 0);

    // R2: a trigger held high counts once
    do_reset();
    slave_mode = 3'b111; trig_sel = 3'd1; cnt_en = 1'b1;
    trig_in[1] = 1'b1;
    run(12);
    chk("R2 level counts once", int'(count), 1);

    // R5: edge clock with enable low
    do_reset();
    slave_mode = 3'b111; cnt_en = 1'b0;
    pulses(0, 3);
    run(3);
    chk("R5 edges ignored when disabled", int'(count), 0);

    // R3 / R4: gated with short windows, phase kept across gaps
    do_reset();
    slave_mode = 3'b101; trig_sel = 3'd2; psc_div = 16'd2; cnt_en = 1'b1;
    run(5);
    chk("R3 gate low no count", int'(count), 0);
    begin
      int spans[4] = '{4, 1, 2, 5};
      int total = 0;
      foreach (spans[i]) begin
        trig_in[2] = 1'b1; run(spans[i]);
        trig_in[2] = 1'b0; run(3);
        total += spans[i];
      end
      chk("R4 gated phase kept", int'(count), total / 3);
    end

    // R3: long gate window
    do_reset();
    slave_mode = 3'b101; trig_sel = 3'd0; psc_div = 16'd1; cnt_en = 1'b1;
    trig_in[0] = 1'b1; run(10);
    trig_in[0] = 1'b0; run(4);
    chk("R3 gated long window", int'(count), 5);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule